// File: doc/BRIEF.md
# Key-protected system control register

This block is an 8-bit control register on a simple memory-mapped peripheral bus. It holds one clock-ratio select bit and four module-stop bits. It drives them straight out to the clock-generation and power-management logic.

Ordinary writes cannot change the register by accident. A write lands only when it is a 16-bit access whose upper byte equals a fixed key. The lower byte of that access then carries the new contents. Byte-size writes and word writes with any other upper byte are dropped with no side effect. Software reads the register with a byte access, as it would any plain register.

Reads are registered: the read data appears on the cycle after the request. In every other cycle the read data is zero.

Top module: `sysctl_keyreg`

## Requirements
- R1: After reset the register holds 0x01. That means `clk_x8` = 0 and `mod_stop` = 4'b0001, and a byte read returns 0x01.
- R2: A request with `req`=1, `we`=1, `size_word`=1 and `addr`=BASE_ADDR is accepted when `wdata[15:8]` equals KEY (0x3C). `clk_x8` then takes `wdata[7]` and `mod_stop` takes `wdata[3:0]`, both on the clock edge that samples the request.
- R3: A byte-size write (`size_word`=0) to BASE_ADDR leaves the register unchanged, whatever the data.
- R4: A word write to BASE_ADDR whose `wdata[15:8]` differs from KEY leaves the register unchanged.
- R5: Bits 6 to 4 always read as 0, even after an accepted write whose `wdata[6:4]` are 1.
- R6: A byte read (`req`=1, `we`=0, `size_word`=0, `addr`=BASE_ADDR) puts the register onto `rdata` on the next cycle. The layout on `rdata` is bit 7 = clock select, bits 6:4 = 0, bits 3:0 = module-stop. In any cycle after a cycle without such a read (idle, word read, or other address), `rdata` is 0x00.
- R7: Writes of any size or key to an address other than BASE_ADDR leave the register unchanged.
- R8: Without `req`, the other bus inputs have no effect on the register.
- R9: `clk_x8` = 0 asks for an internal clock of four times the input clock, and `clk_x8` = 1 asks for eight times. The output follows register bit 7 in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| size_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| addr | input | ADDR_W | Access address |
| wdata | input | 16 | Write data: [15:8] key, [7:0] register data |
| rdata | output | 8 | Registered read data |
| clk_x8 | output | 1 | Clock ratio select: 0 = x4, 1 = x8 |
| mod_stop | output | 4 | Module-stop controls, one per module |

## Verification
A corrupted register shows up at once on `clk_x8` and `mod_stop`, because both come straight from the storage bits. A wrongly accepted or wrongly dropped write is therefore visible on the very next clock edge. A fault in the read path or in the reserved-bit masking shows on `rdata` one cycle after a byte read. Readback of the register after each rejected write shows whether a bad write left a trace.

// File: rtl/sysctl_keyreg.sv
module sysctl_keyreg #(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'h0000_0040,
  parameter logic [7:0]  KEY       = 8'h3C,
  parameter logic [7:0]  RST_VAL   = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic              size_word,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [7:0]        rdata,
  output logic              clk_x8,
  output logic [3:0]        mod_stop
);

  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

  logic       hit;
  logic       wr_ok;
  logic       rd_ok;
  logic       sel_q;
  logic [3:0] stop_q;

  assign hit   = req && (addr == BASE);
  assign wr_ok = hit && we && size_word && (wdata[15:8] == KEY);
  assign rd_ok = hit && !we && !size_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= RST_VAL[7];
      stop_q <= RST_VAL[3:0];
    end else if (wr_ok) begin
      sel_q  <= wdata[7];
      stop_q <= wdata[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= 8'h00;
    else if (rd_ok) rdata <= {sel_q, 3'b000, stop_q};
    else            rdata <= 8'h00;
  end

  assign clk_x8   = sel_q;
  assign mod_stop = stop_q;

endmodule

module sysctl_keyreg_chk #(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'h0000_0040,
  parameter logic [7:0]  KEY       = 8'h3C,
  parameter logic [7:0]  RST_VAL   = 8'h01
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              we,
  input logic              size_word,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       wdata,
  input logic [7:0]        rdata,
  input logic              clk_x8,
  input logic [3:0]        mod_stop
);

  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

  // R1
  reset_value_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (clk_x8 == RST_VAL[7] && mod_stop == RST_VAL[3:0]));

  // R2
  key_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && size_word && addr == BASE && wdata[15:8] == KEY)
    |=> (clk_x8 == $past(wdata[7]) && mod_stop == $past(wdata[3:0])));

  // R3
  byte_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && !size_word) |=> $stable({clk_x8, mod_stop}));

  // R4
  bad_key_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && size_word && wdata[15:8] != KEY) |=> $stable({clk_x8, mod_stop}));

  // R5
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[6:4] == 3'b000);

  // R6
  read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && !size_word && addr == BASE)
    |=> (rdata == {clk_x8, 3'b000, mod_stop}));

  // R6
  read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !we && !size_word && addr == BASE) |=> (rdata == 8'h00));

  // R7
  other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && addr != BASE) |=> $stable({clk_x8, mod_stop}));

  // R8
  no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable({clk_x8, mod_stop}));

endmodule

bind sysctl_keyreg sysctl_keyreg_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .KEY(KEY), .RST_VAL(RST_VAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .size_word(size_word),
  .addr(addr), .wdata(wdata), .rdata(rdata), .clk_x8(clk_x8), .mod_stop(mod_stop)
);

// File: tb/tb_sysctl_keyreg.sv
module tb_sysctl_keyreg;
  localparam int          CLK_PERIOD = 10;
  localparam int          ADDR_W     = 32;
  localparam logic [31:0] BASE       = 32'h0000_0040;
  localparam logic [7:0]  KEY        = 8'h3C;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0;
  logic              we = 1'b0;
  logic              size_word = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0]       wdata = '0;
  logic [7:0]        rdata;
  logic              clk_x8;
  logic [3:0]        mod_stop;

  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_keyreg #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE), .KEY(KEY)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .size_word(size_word),
    .addr(addr), .wdata(wdata), .rdata(rdata), .clk_x8(clk_x8), .mod_stop(mod_stop)
  );

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic outs_are(string tag, logic [7:0] exp);
    check8(tag, {clk_x8, 3'b000, mod_stop}, {exp[7], 3'b000, exp[3:0]});
  endtask

  task automatic access(input logic r, input logic w, input logic sz,
                        input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk);
    req = r; we = w; size_word = sz; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; size_word = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic read_byte(output logic [7:0] v);
    @(negedge clk);
    req = 1'b1; we = 1'b0; size_word = 1'b0; addr = BASE;
    @(negedge clk);
    v = rdata;
    req = 1'b0; addr = '0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    outs_are("R1 reset outputs", 8'h01);
    read_byte(v);
    check8("R1 reset readback", v, 8'h01);
  endtask

  task automatic t_accept();
    logic [7:0] v;
    access(1, 1, 1, BASE, {KEY, 8'h8A});
    outs_are("R2 key write outputs", 8'h8A);
    check8("R9 x8 selected", {7'd0, clk_x8}, 8'h01);
    read_byte(v);
    check8("R2 key write readback", v, 8'h8A);
    access(1, 1, 1, BASE, {KEY, 8'h05});
    outs_are("R2 second key write", 8'h05);
    check8("R9 x4 selected", {7'd0, clk_x8}, 8'h00);
  endtask

  task automatic t_byte_write();
    logic [7:0] v;
    access(1, 1, 0, BASE, {KEY, 8'hFF});
    outs_are("R3 byte write with key ignored", 8'h05);
    access(1, 1, 0, BASE, 16'h00FA);
    read_byte(v);
    check8("R3 byte write readback", v, 8'h05);
  endtask

  task automatic t_bad_key();
    logic [7:0] v;
    access(1, 1, 1, BASE, 16'h3D8F);
    outs_are("R4 wrong key 0x3D", 8'h05);
    access(1, 1, 1, BASE, 16'h008F);
    outs_are("R4 wrong key 0x00", 8'h05);
    access(1, 1, 1, BASE, 16'hC38F);
    read_byte(v);
    check8("R4 wrong key readback", v, 8'h05);
  endtask

  task automatic t_reserved();
    logic [7:0] v;
    access(1, 1, 1, BASE, {KEY, 8'hFF});
    read_byte(v);
    check8("R5 reserved bits read zero", v, 8'h8F);
    access(1, 1, 1, BASE, {KEY, 8'h70});
    read_byte(v);
    check8("R5 only reserved bits written", v, 8'h00);
  endtask

  task automatic t_read_path();
    access(1, 1, 1, BASE, {KEY, 8'h83});
    @(negedge clk);
    check8("R6 idle rdata zero", rdata, 8'h00);
    access(1, 0, 1, BASE, 16'h0000);
    check8("R6 word read gives zero", rdata, 8'h00);
    access(1, 0, 0, BASE + 32'd2, 16'h0000);
    check8("R6 read other address zero", rdata, 8'h00);
    access(1, 0, 0, BASE, 16'h0000);
    check8("R6 byte read data", rdata, 8'h83);
    @(negedge clk);
    check8("R6 rdata clears after read", rdata, 8'h00);
  endtask

  task automatic t_other_addr();
    access(1, 1, 1, BASE + 32'd1, {KEY, 8'h0C});
    outs_are("R7 key write other address", 8'h83);
    access(1, 1, 0, BASE - 32'd4, 16'h0000);
    outs_are("R7 byte write other address", 8'h83);
  endtask

  task automatic t_no_req();
    access(0, 1, 1, BASE, {KEY, 8'h0E});
    outs_are("R8 no request ignored", 8'h83);
  endtask

  task automatic t_reset_again();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    outs_are("R1 reset after writes", 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_accept();
    t_byte_write();
    t_bad_key();
    t_reserved();
    t_read_path();
    t_other_addr();
    t_no_req();
    t_reset_again();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule